// File: doc/BRIEF.md
# Trigger-Driven Port Scrub Sequencer

This block sits on a bundle of parallel symbol lanes, one per indicate port. It holds an active port-configuration word. When scrubbing is enabled and a trigger arrives, it swaps a preloaded alternate word into that register. It then overwrites the output of every lane whose configuration bit changed with a clean-up pattern: two invalid symbols, followed by a programmable number of scrub-symbol pairs. After the last pair, those lanes carry their normal data again. Lanes whose bit did not change carry their normal stream throughout.

While scrubbing is disabled, the active register copies a base configuration word on every cycle. This lets the surrounding logic set the starting configuration before it arms the trigger. The sequence counts transferred beats, not clock cycles. The symbol bundle passes through with a shared valid/ready handshake. Back-pressure from the sink stalls the source and the scrub sequence together. A stalled beat is held, and it is neither counted nor skipped.

Top module: `scrub_trig_seq`

## Requirements
- R1: After reset, `busy` is 0, the active configuration register is 0, and every output lane equals its input lane.
- R2: A trigger is accepted only in a cycle where `trig` is 1, `scrub_en` is 1 and `busy` is 0. When `scrub_en` is 0, `trig` has no effect on `busy` or on the lanes.
- R3: On an accepted trigger, `cfg_alt` is copied into the active register. The set of changed lanes is the bitwise XOR of the old active word and `cfg_alt`.
- R4: A lane whose configuration bit did not change outputs its input symbol in every cycle. Every lane does the same whenever `busy` is 0.
- R5: Over the first two transferred beats of a sequence, each changed lane outputs the invalid symbol 5'b00000.
- R6: After those two beats, each changed lane outputs the scrub symbol 5'b00100 for 2*`scrub_thr` beats. `scrub_thr` is the 16-bit value sampled when the trigger is accepted.
- R7: A `scrub_thr` of 0 gives exactly two invalid-symbol beats and no scrub symbols.
- R8: `busy` rises in the cycle after an accepted trigger. It falls in the cycle after the final beat of the sequence transfers. A sequence therefore lasts exactly 2+2*`scrub_thr` beats.
- R9: A trigger that arrives while `busy` is 1 is ignored. It neither restarts the sequence nor reloads the active register.
- R10: The bundle handshake is combinational: `m_valid` equals `s_valid` and `s_ready` equals `m_ready`. A beat transfers only when `s_valid` and `m_ready` are both 1. The sequence advances only on such beats.
- R11: If `cfg_alt` equals the active word, an accepted trigger still loads it, but no sequence starts and `busy` stays 0.
- R12: While `scrub_en` is 0 and `busy` is 0, the active register takes `cfg_base` on every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Trigger condition from upstream detection |
| scrub_en | input | 1 | Scrub-on-trigger enable |
| cfg_base | input | NPORT | Configuration copied while scrubbing is disabled |
| cfg_alt | input | NPORT | Alternate configuration loaded on trigger |
| scrub_thr | input | THR_W | Number of scrub-symbol pairs |
| s_valid | input | 1 | Input bundle valid |
| s_ready | output | 1 | Input bundle ready |
| s_sym | input | NPORT*5 | Input symbols, lane i at bits [5i+4:5i] |
| m_valid | output | 1 | Output bundle valid |
| m_ready | input | 1 | Output bundle ready |
| m_sym | output | NPORT*5 | Output symbols, lane i at bits [5i+4:5i] |
| busy | output | 1 | High while a scrub sequence is in progress |

## Verification
A wrong beat counter shows up at the lane outputs on the first stalled or final beat. A missed advance stretches the invalid prefix, and a spurious one shortens it. An off-by-one end shows as one beat too many or too few before `busy` falls. A wrong changed-lane mask corrupts an unchanged lane in the very first busy cycle. A wrong active register stays hidden until the next trigger. The bench therefore fires a repeat trigger with the same word after each sequence, and expects no `busy` in response.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int SYM_W = 5;
  localparam logic [SYM_W-1:0] INV_SYM   = 5'b00000;
  localparam logic [SYM_W-1:0] SCRUB_SYM = 5'b00100;

  typedef enum logic [1:0] {
    SEL_PASS  = 2'd0,
    SEL_INV   = 2'd1,
    SEL_SCRUB = 2'd2
  } lane_sel_e;
endpackage

// File: rtl/scrub_cfg_reg.sv
module scrub_cfg_reg #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             follow,
  input  logic [NPORT-1:0] base,
  input  logic [NPORT-1:0] alt,
  output logic [NPORT-1:0] chg,
  output logic             differs
);
  logic [NPORT-1:0] act_q;
  logic [NPORT-1:0] chg_q;

  assign differs = |(act_q ^ alt);
  assign chg     = chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      chg_q <= '0;
    end else if (take) begin
      chg_q <= act_q ^ alt;
      act_q <= alt;
    end else if (follow) begin
      act_q <= base;
    end
  end
endmodule

// File: rtl/scrub_seq_ctrl.sv
module scrub_seq_ctrl #(
  parameter int THR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [THR_W-1:0] thr,
  input  logic             beat,
  output logic             busy,
  output logic             in_prefix
);
  localparam int IDX_W = THR_W + 2;

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic             busy_q;

  assign busy      = busy_q;
  assign in_prefix = (idx_q[IDX_W-1:1] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      last_q <= {1'b0, thr, 1'b1};
    end else if (busy_q && beat) begin
      if (idx_q == last_q) busy_q <= 1'b0;
      else                 idx_q  <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/scrub_lane_mux.sv
module scrub_lane_mux
  import scrub_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic                   busy,
  input  logic                   in_prefix,
  input  logic [NPORT-1:0]       chg,
  input  logic [NPORT*SYM_W-1:0] din,
  output logic [NPORT*SYM_W-1:0] dout
);
  for (genvar g = 0; g < NPORT; g++) begin : g_lane
    lane_sel_e sel;
    always_comb begin
      if (busy && chg[g]) sel = in_prefix ? SEL_INV : SEL_SCRUB;
      else                sel = SEL_PASS;
    end
    always_comb begin
      unique case (sel)
        SEL_INV:   dout[g*SYM_W +: SYM_W] = INV_SYM;
        SEL_SCRUB: dout[g*SYM_W +: SYM_W] = SCRUB_SYM;
        default:   dout[g*SYM_W +: SYM_W] = din[g*SYM_W +: SYM_W];
      endcase
    end
  end
endmodule

// File: rtl/scrub_trig_seq.sv
module scrub_trig_seq
  import scrub_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int THR_W = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig,
  input  logic                   scrub_en,
  input  logic [NPORT-1:0]       cfg_base,
  input  logic [NPORT-1:0]       cfg_alt,
  input  logic [THR_W-1:0]       scrub_thr,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [NPORT*SYM_W-1:0] s_sym,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [NPORT*SYM_W-1:0] m_sym,
  output logic                   busy
);
  logic             take;
  logic             follow;
  logic             differs;
  logic             beat;
  logic             in_prefix;
  logic [NPORT-1:0] chg;

  assign take    = trig && scrub_en && !busy;
  assign follow  = !scrub_en && !busy;
  assign beat    = s_valid && m_ready;
  assign s_ready = m_ready;
  assign m_valid = s_valid;

  scrub_cfg_reg #(.NPORT(NPORT)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .follow  (follow),
    .base    (cfg_base),
    .alt     (cfg_alt),
    .chg     (chg),
    .differs (differs)
  );

  scrub_seq_ctrl #(.THR_W(THR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (take && differs),
    .thr       (scrub_thr),
    .beat      (beat),
    .busy      (busy),
    .in_prefix (in_prefix)
  );

  scrub_lane_mux #(.NPORT(NPORT)) u_mux (
    .busy      (busy),
    .in_prefix (in_prefix),
    .chg       (chg),
    .din       (s_sym),
    .dout      (m_sym)
  );
endmodule

// File: rtl/scrub_trig_seq_chk.sv
module scrub_trig_seq_chk #(
  parameter int NPORT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trig,
  input logic               scrub_en,
  input logic               s_valid,
  input logic               s_ready,
  input logic               m_valid,
  input logic               m_ready,
  input logic [NPORT*5-1:0] s_sym,
  input logic [NPORT*5-1:0] m_sym,
  input logic [NPORT-1:0]   chg,
  input logic               busy
);
  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (m_sym == s_sym));                                            // R4
  AST_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid == s_valid) && (s_ready == m_ready));                          // R10
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig && scrub_en));                               // R2
  AST_HOLD_WITHOUT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(s_valid && m_ready)) |=> busy);                              // R8
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (chg != '0));                                                  // R11
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chg));                                // R9
endmodule

bind scrub_trig_seq scrub_trig_seq_chk #(.NPORT(NPORT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .trig     (trig),
  .scrub_en (scrub_en),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .s_sym    (s_sym),
  .m_sym    (m_sym),
  .chg      (chg),
  .busy     (busy)
);

// File: tb/sim_scrub_trig_seq.sv
`timescale 1ns/100ps
module sim_scrub_trig_seq;
  localparam int NP = 4;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trig = 1'b0;
  logic          scrub_en = 1'b0;
  logic [NP-1:0] cfg_base = '0;
  logic [NP-1:0] cfg_alt = '0;
  logic [TW-1:0] scrub_thr = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [NP*5-1:0] s_sym = '0;
  logic          m_valid;
  logic          m_ready = 1'b0;
  logic [NP*5-1:0] m_sym;
  logic          busy;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  scrub_trig_seq #(.NPORT(NP), .THR_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .trig(trig), .scrub_en(scrub_en),
    .cfg_base(cfg_base), .cfg_alt(cfg_alt), .scrub_thr(scrub_thr),
    .s_valid(s_valid), .s_ready(s_ready), .s_sym(s_sym),
    .m_valid(m_valid), .m_ready(m_ready), .m_sym(m_sym), .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [NP-1:0] m_act;
    logic [NP-1:0] m_chg;
    bit            mb;
    int            midx, mlast, beats, cyc;
    logic [4:0]    lane, expl;
    cyc = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    s_sym = 20'h1_2345;
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 pass", m_sym, s_sym);
    rst_n = 1'b1;
    m_act = '0;
    for (int b = 0; b < 16; b++) begin
      for (int a = 0; a < 16; a++) begin
        // R2/R12: disabled trigger only tracks cfg_base
        @(negedge clk);
        scrub_en = 0; cfg_base = b[NP-1:0]; cfg_alt = a[NP-1:0];
        trig = 1; s_valid = 1; m_ready = 1;
        @(posedge clk);
        m_act = b[NP-1:0];
        @(negedge clk);
        trig = 0;
        #1 chk("R2 disabled trigger", busy, 0);
        // arm and fire
        @(negedge clk);
        scrub_en = 1; trig = 1; scrub_thr = TW'((a + b) % 4);
        #1 chk("R8 not busy yet", busy, 0);
        @(posedge clk);
        mb = (m_act != a[NP-1:0]);
        m_chg = m_act ^ a[NP-1:0];
        m_act = a[NP-1:0];
        midx = 0; mlast = 2 * ((a + b) % 4) + 1; beats = 0;
        if (!mb) begin
          @(negedge clk);
          #1 chk("R11 no change no busy", busy, 0);
        end
        for (int k = 0; k < 64 && mb; k++) begin
          @(negedge clk);
          cyc++;
          trig = 1; cfg_alt = ~a[NP-1:0]; scrub_thr = 3;   // R9 ignored while busy
          s_valid = ((cyc * 7 + a) % 5) != 0;
          m_ready = ((cyc * 5 + b) % 4) != 1;
          for (int i = 0; i < NP; i++) s_sym[i*5 +: 5] = 5'((cyc * 3 + i * 11) & 31);
          #1;
          chk("R8 busy", busy, 1);
          chk("R10 valid", m_valid, s_valid);
          chk("R10 ready", s_ready, m_ready);
          for (int i = 0; i < NP; i++) begin
            lane = s_sym[i*5 +: 5];
            if (!m_chg[i])      expl = lane;
            else if (midx < 2)  expl = 5'b00000;
            else                expl = 5'b00100;
            chk(!m_chg[i] ? "R4 unchanged lane" : (midx < 2 ? "R5 invalid" : "R6 scrub"),
                m_sym[i*5 +: 5], expl);
          end
          @(posedge clk);
          if (s_valid && m_ready) begin
            beats++;
            if (midx == mlast) mb = 0;
            else midx++;
          end
        end
        @(negedge clk);
        trig = 0; cfg_alt = a[NP-1:0]; s_valid = 1; m_ready = 1;
        #1;
        chk("R8 busy falls", busy, 0);
        chk("R4 idle pass", m_sym, s_sym);
        if (m_chg != 0 && m_act == a[NP-1:0])
          chk((a + b) % 4 == 0 ? "R7 beats thr0" : "R6 beat count", beats,
              m_chg != 0 ? 2 + 2 * ((a + b) % 4) : 0);
        // R3/R9: active must hold cfg_alt, not the value offered mid-sequence
        trig = 1;
        @(posedge clk);
        @(negedge clk);
        trig = 0;
        #1 chk("R3 active word kept", busy, 0);
        m_chg = '0;
      end
    end
    finish_run();
  end
endmodule